// File: doc/BRIEF.md
# Master Clock Rate Autodetect Prescaler

This block works out the speed of an unknown master clock by counting its cycles across each period of an 8 kHz frame sync, which is sampled in the master clock domain. It compares each period measurement against a set of supported rates. When two consecutive measurements name the same rate, it declares lock. While locked, it divides the master clock down to a 256 kHz sequencing enable: one single-cycle strobe at a time, exactly 32 per frame. The divider phase restarts at every frame sync rising edge, so the strobes always line up with the frame.

The divide ratio is never programmed; it follows from the detected rate. At 1544 kHz a frame holds 193 cycles, which is not a whole multiple of 32. For that rate the divider spaces the strobes 6 cycles apart and leaves the final cycle of the frame idle.

The lock controller has three states: `ST_HUNT` (no candidate), `ST_CAND` (one classified measurement held as candidate) and `ST_LOCK`.
- `ST_HUNT` moves to `ST_CAND` on a matching measurement.
- `ST_CAND` moves to `ST_LOCK` when the next measurement matches the candidate. It stays in `ST_CAND` with a new candidate when that measurement matches a different rate. It falls back to `ST_HUNT` on a non-matching measurement or a timeout.
- `ST_LOCK` holds while measurements agree. It moves to `ST_CAND` when a measurement matches a different rate. It moves to `ST_HUNT` on a non-matching measurement or a timeout.

Top module: `mclk_rate_prescaler`

## Requirements
- R1: While reset is asserted, and right after it is released, `locked` is 0, `rate_code` is 7 and `seq_en` is 0.
- R2: `fs_in` is sampled on every rising clock edge. A rise is an edge at which `fs_in` is sampled high after being sampled low. A measurement is the number of clock edges from one rise to the next. The first rise after reset, or after a timeout, only serves as a reference and yields no measurement.
- R3: A measurement classifies as follows:
  - Nominal counts per frame: code 0 = 32, code 1 = 64, code 2 = 192, code 3 = 193, code 4 = 256, code 5 = 320, code 6 = 512.
  - An exact hit on a nominal count wins.
  - Otherwise, a count within ±1 of a nominal count takes the lowest such code. So 191 gives code 2, and both 193 and 194 give code 3.
  - Any other count is a miss.
- R4: `locked` rises only after two consecutive measurements classify to the same code, which takes three rises from reset. While `locked` is 1, `rate_code` shows that code. While `locked` is 0, `rate_code` is 7.
- R5: The strobe pattern while locked is as follows:
  - Let the ratio R be 1, 2, 6, 6, 8, 10 or 16 for codes 0 to 6.
  - Let E0 be the edge of a frame's rise. `seq_en` is high for the cycle after each edge E0 + k·R, for k = 0..31, and low in every other cycle of that frame.
- R6: At code 3 (193 cycles per frame), the 32 strobes are spaced 6 cycles apart and the last cycle of the frame carries no strobe.
- R7: A measurement that misses every supported rate clears `locked` and sets `rate_code` to 7. After that, `seq_en` stays low.
- R8: While locked, a measurement that classifies to a different code clears `locked`. The next measurement that agrees with the new code locks to it.
- R9: If `fs_in` shows no rise for more than 1024 clock edges, `locked` drops; it stays set for at least 1024 edges after the last rise.
- R10: `seq_en` is never high unless `locked` was high in the previous cycle. Measurements that alternate between codes therefore produce no strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock of unknown rate |
| rst_n | input | 1 | Active-low synchronous reset |
| fs_in | input | 1 | 8 kHz frame sync, synchronous to clk |
| rate_code | output | 3 | Detected rate code 0..6, 7 when unlocked |
| locked | output | 1 | High while a rate is confirmed |
| seq_en | output | 1 | 256 kHz sequencing enable strobe |

## Verification
The checks made on every cycle are these:
- Measurement pulses never come back to back.
- A rise while locked always produces a strobe on the next cycle.
- A strobe is never emitted unless lock was held one cycle before.
- Lock rises only on a measurement.
- A miss or a timeout always clears lock on the next cycle.

Some behaviour only the scenarios can show:
- The exact position of all 32 strobes in a frame for each of the seven rates, including the idle tail at 193 cycles.
- The ±1 tolerance and the 191/193/194 boundary choices.
- The three-rise lock latency.
- The 1024-cycle timeout window.
- Re-locking to a new rate.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

    localparam int NUM_RATES   = 7;
    localparam int FRAME_SLOTS = 32;
    localparam logic [2:0] CODE_NONE = 3'd7;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_CAND,
        ST_LOCK
    } lock_state_t;

    // master clock cycles per 8 kHz frame, ascending frequency order
    function automatic int nominal_count(input int idx);
        int res;
        case (idx)
            0:       res = 32;
            1:       res = 64;
            2:       res = 192;
            3:       res = 193;
            4:       res = 256;
            5:       res = 320;
            6:       res = 512;
            default: res = 0;
        endcase
        return res;
    endfunction

    localparam int MAX_RATIO = nominal_count(NUM_RATES - 1) / FRAME_SLOTS;
    localparam int RATIO_W   = $clog2(MAX_RATIO + 1);

    // integer division gives 6 for 193: the remaining cycle stays idle
    function automatic logic [RATIO_W-1:0] ratio_of(input logic [2:0] code);
        return RATIO_W'(nominal_count(int'(code)) / FRAME_SLOTS);
    endfunction

endpackage

// File: rtl/mcd_frame_meter.sv
module mcd_frame_meter #(
    parameter int TIMEOUT = 1024,
    parameter int CNT_W   = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fs_in,
    output logic             fs_rise,
    output logic             meas_vld,
    output logic [CNT_W-1:0] meas_cnt,
    output logic             timeout
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             fs_q;
    logic             have_ref;
    logic [CNT_W-1:0] run_cnt;

    assign fs_rise = fs_in & ~fs_q;
    assign timeout = (run_cnt > CNT_W'(TIMEOUT));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q     <= 1'b0;
            have_ref <= 1'b0;
            run_cnt  <= '0;
            meas_vld <= 1'b0;
            meas_cnt <= '0;
        end else begin
            fs_q     <= fs_in;
            meas_vld <= 1'b0;
            if (fs_rise) begin
                run_cnt  <= CNT_W'(1);
                have_ref <= 1'b1;
                meas_vld <= have_ref & ~timeout;
                meas_cnt <= run_cnt;
            end else if (run_cnt != CNT_MAX) begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    // R2: one measurement per rise, never on consecutive cycles
    a_r2_meas_single: assert property (@(posedge clk) disable iff (!rst_n)
        meas_vld |=> !meas_vld);

endmodule

// File: rtl/mcd_rate_classifier.sv
module mcd_rate_classifier
    import mcd_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int TOL   = 1
) (
    input  logic [CNT_W-1:0] meas_cnt,
    output logic             hit,
    output logic [2:0]       code
);

    logic [NUM_RATES-1:0] exact;
    logic [NUM_RATES-1:0] near;

    for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
        localparam int NOM = nominal_count(g);
        assign exact[g] = (int'(meas_cnt) == NOM);
        assign near[g]  = (int'(meas_cnt) >= NOM - TOL) && (int'(meas_cnt) <= NOM + TOL);
    end

    always_comb begin
        hit  = |near;
        code = CODE_NONE;
        for (int i = NUM_RATES - 1; i >= 0; i--) begin
            if (near[i]) code = 3'(i);
        end
        for (int i = NUM_RATES - 1; i >= 0; i--) begin
            if (exact[i]) code = 3'(i);
        end
    end

endmodule

// File: rtl/mcd_lock_fsm.sv
module mcd_lock_fsm
    import mcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       meas_vld,
    input  logic       hit,
    input  logic [2:0] meas_code,
    input  logic       timeout,
    output logic       locked,
    output logic [2:0] rate_code
);

    lock_state_t state_q, state_d;
    logic [2:0]  cand_q, cand_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            cand_q  <= CODE_NONE;
        end else begin
            state_q <= state_d;
            cand_q  <= cand_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cand_d  = cand_q;
        unique case (state_q)
            ST_HUNT: begin
                if (meas_vld && hit) begin
                    state_d = ST_CAND;
                    cand_d  = meas_code;
                end
            end
            ST_CAND: begin
                if (timeout) begin
                    state_d = ST_HUNT;
                end else if (meas_vld) begin
                    if (!hit) begin
                        state_d = ST_HUNT;
                    end else if (meas_code == cand_q) begin
                        state_d = ST_LOCK;
                    end else begin
                        cand_d  = meas_code;
                    end
                end
            end
            ST_LOCK: begin
                if (timeout) begin
                    state_d = ST_HUNT;
                end else if (meas_vld) begin
                    if (!hit) begin
                        state_d = ST_HUNT;
                    end else if (meas_code != cand_q) begin
                        state_d = ST_CAND;
                        cand_d  = meas_code;
                    end
                end
            end
            default: state_d = ST_HUNT;
        endcase
    end

    always_comb begin
        locked    = (state_q == ST_LOCK);
        rate_code = locked ? cand_q : CODE_NONE;
    end

    // R4: lock is only ever gained on a measurement
    a_r4_lock_on_meas: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(meas_vld));

    // R7: a miss clears lock
    a_r7_miss_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_vld && !hit) |=> !locked);

    // R9: a missing frame sync clears lock
    a_r9_timeout_drops: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !locked);

endmodule

// File: rtl/mcd_seq_divider.sv
module mcd_seq_divider #(
    parameter int FRAME_SLOTS = 32,
    parameter int RATIO_W     = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fs_rise,
    input  logic               locked,
    input  logic [RATIO_W-1:0] ratio,
    output logic               seq_en
);

    localparam int SLOT_W = $clog2(FRAME_SLOTS + 1);
    localparam logic [SLOT_W-1:0] SLOT_END = SLOT_W'(FRAME_SLOTS);

    logic [RATIO_W-1:0] phase_q, phase_d;
    logic [SLOT_W-1:0]  slot_q, slot_d;
    logic               strobe;

    always_comb begin
        strobe  = 1'b0;
        phase_d = phase_q;
        slot_d  = slot_q;
        if (!locked) begin
            phase_d = '0;
            slot_d  = SLOT_END;
        end else if (fs_rise) begin
            strobe  = 1'b1;
            slot_d  = SLOT_W'(1);
            phase_d = (ratio == RATIO_W'(1)) ? '0 : RATIO_W'(1);
        end else begin
            strobe  = (phase_q == '0) && (slot_q < SLOT_END);
            if (strobe) slot_d = slot_q + 1'b1;
            phase_d = (phase_q == ratio - 1'b1) ? '0 : phase_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            slot_q  <= SLOT_END;
            seq_en  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            slot_q  <= slot_d;
            seq_en  <= strobe;
        end
    end

    // R10: no strobe without lock in the previous cycle
    a_r10_quiet_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        seq_en |-> $past(locked));

    // R5: a rise while locked restarts the divider with slot 0
    a_r5_rise_realign: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_rise && locked) |=> seq_en);

endmodule

// File: rtl/mclk_rate_prescaler.sv
module mclk_rate_prescaler
    import mcd_pkg::*;
#(
    parameter int TIMEOUT = 1024,
    parameter int TOL     = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fs_in,
    output logic [2:0] rate_code,
    output logic       locked,
    output logic       seq_en
);

    localparam int CNT_W = $clog2(TIMEOUT + 2) + 1;

    logic             fs_rise;
    logic             meas_vld;
    logic [CNT_W-1:0] meas_cnt;
    logic             timeout;
    logic             hit;
    logic [2:0]       meas_code;
    logic [RATIO_W-1:0] ratio;

    mcd_frame_meter #(.TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) u_meter (
        .clk      (clk),
        .rst_n    (rst_n),
        .fs_in    (fs_in),
        .fs_rise  (fs_rise),
        .meas_vld (meas_vld),
        .meas_cnt (meas_cnt),
        .timeout  (timeout)
    );

    mcd_rate_classifier #(.CNT_W(CNT_W), .TOL(TOL)) u_class (
        .meas_cnt (meas_cnt),
        .hit      (hit),
        .code     (meas_code)
    );

    mcd_lock_fsm u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .meas_vld  (meas_vld),
        .hit       (hit),
        .meas_code (meas_code),
        .timeout   (timeout),
        .locked    (locked),
        .rate_code (rate_code)
    );

    assign ratio = ratio_of(rate_code);

    mcd_seq_divider #(.FRAME_SLOTS(FRAME_SLOTS), .RATIO_W(RATIO_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .fs_rise (fs_rise),
        .locked  (locked),
        .ratio   (ratio),
        .seq_en  (seq_en)
    );

endmodule

// File: tb/mclk_rate_prescaler_tb.sv
module mclk_rate_prescaler_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fs_in = 1'b0;
    logic [2:0] rate_code;
    logic       locked;
    logic       seq_en;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    mclk_rate_prescaler dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fs_in     (fs_in),
        .rate_code (rate_code),
        .locked    (locked),
        .seq_en    (seq_en)
    );

    task automatic check_val(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        fs_in = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // one frame of n cycles; ratio 0 expects no strobe at all
    task automatic run_frame(input int n, input int ratio, input bit chk, input string req);
        int bad = 0;
        for (int j = 0; j < n; j++) begin
            bit exp;
            fs_in = (j < n / 2);
            @(negedge clk);
            exp = (ratio != 0) && (j % ratio == 0) && (j / ratio < 32);
            if (seq_en !== exp) bad++;
        end
        if (chk) check_val(req, "strobe pattern mismatches", bad, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_val("R1", "locked in reset", int'(locked), 0);
        check_val("R1", "code in reset", int'(rate_code), 7);
        check_val("R1", "seq_en in reset", int'(seq_en), 0);
        do_reset();
        check_val("R1", "locked after reset", int'(locked), 0);
        check_val("R1", "code after reset", int'(rate_code), 7);
    endtask

    task automatic t_rate(input int code, input int n);
        string req = (code == 3) ? "R6" : "R5";
        do_reset();
        repeat (3) run_frame(n, n / 32, 1'b0, req);
        run_frame(n, n / 32, 1'b1, req);
        run_frame(n, n / 32, 1'b1, req);
        check_val("R4", "locked at rate", int'(locked), 1);
        check_val("R3", "rate code", int'(rate_code), code);
    endtask

    task automatic t_lock_latency();
        do_reset();
        run_frame(64, 0, 1'b1, "R10");
        run_frame(64, 0, 1'b1, "R10");
        check_val("R2", "locked after one measurement", int'(locked), 0);
        run_frame(64, 2, 1'b0, "R4");
        check_val("R4", "locked after two agreeing", int'(locked), 1);
        check_val("R4", "code after lock", int'(rate_code), 1);
    endtask

    task automatic t_tolerance(input int n, input int code);
        do_reset();
        repeat (4) run_frame(n, 0, 1'b0, "R3");
        check_val("R3", "locked with tolerance", int'(locked), 1);
        check_val("R3", "code with tolerance", int'(rate_code), code);
    endtask

    task automatic t_miss();
        do_reset();
        repeat (4) run_frame(64, 2, 1'b0, "R7");
        run_frame(100, 0, 1'b0, "R7");
        run_frame(100, 0, 1'b0, "R7");
        check_val("R7", "locked after miss", int'(locked), 0);
        check_val("R7", "code after miss", int'(rate_code), 7);
        run_frame(100, 0, 1'b1, "R7");
    endtask

    task automatic t_change();
        do_reset();
        repeat (4) run_frame(64, 2, 1'b0, "R8");
        check_val("R8", "locked at first rate", int'(locked), 1);
        run_frame(32, 0, 1'b0, "R8");
        run_frame(32, 0, 1'b0, "R8");
        check_val("R8", "locked after rate change", int'(locked), 0);
        check_val("R8", "code after rate change", int'(rate_code), 7);
        run_frame(32, 1, 1'b0, "R8");
        check_val("R8", "relocked", int'(locked), 1);
        check_val("R8", "new code", int'(rate_code), 0);
        run_frame(32, 1, 1'b1, "R8");
    endtask

    task automatic t_alternate();
        do_reset();
        for (int k = 0; k < 3; k++) begin
            run_frame(64, 0, 1'b1, "R10");
            run_frame(32, 0, 1'b1, "R10");
        end
        check_val("R4", "locked on alternating rates", int'(locked), 0);
    endtask

    task automatic t_timeout();
        do_reset();
        repeat (4) run_frame(256, 8, 1'b0, "R9");
        repeat (700) @(negedge clk);
        check_val("R9", "locked before window ends", int'(locked), 1);
        repeat (100) @(negedge clk);
        check_val("R9", "locked after timeout", int'(locked), 0);
        check_val("R9", "code after timeout", int'(rate_code), 7);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_rate(0, 32);
        t_rate(1, 64);
        t_rate(2, 192);
        t_rate(3, 193);
        t_rate(4, 256);
        t_rate(5, 320);
        t_rate(6, 512);
        t_lock_latency();
        t_tolerance(65, 1);
        t_tolerance(191, 2);
        t_tolerance(194, 3);
        t_miss();
        t_change();
        t_alternate();
        t_timeout();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule